// File: doc/BRIEF.md
# Line Interface Hook and Caller-ID Sequencer

This block controls the switch-hook of a telephone line interface and decides when the caller-ID capture path may run. It drives an active-low hook control. High means on-hook, with ring detection and caller-ID monitoring live. Low means off-hook, with loop current flowing. After reset it holds the line on-hook for a mandatory initialization interval. A host request to go off-hook that arrives in that interval is remembered and applied once the interval ends.

Ring events reach the block already qualified, as separate start-of-burst and end-of-burst strobes. A region mode input picks how caller-ID capture is ordered against ringing. In post-ring mode, capture opens only in the silent gap after the first burst of a call. In pre-ring mode, capture stays open for the whole time the line is idle or ringing on-hook. After a hang-up, a guard interval keeps the line on-hook and discards ring events. All timing is counted on a one-millisecond tick. Demodulation of the caller-ID data is done elsewhere.

Top module: `hookCidSequencer`

## Requirements
- R1: After reset, stateCode is 0 (init), hookN is 1 and cidEnable is 0. hookN stays 1 until INIT_MS msTick pulses have been counted.
- R2: An offHookReq seen during init is held pending and takes the line off-hook when init ends. A hangUpReq seen during init cancels the pending request, and init then ends in idle.
- R3: From idle, ringing or caller-ID window, offHookReq without hangUpReq sets hookN to 0 at the next clock edge. When both requests arrive together, hangUpReq wins and the line stays on-hook.
- R4: cidEnable is 0 whenever hookN is 0, and also during init and guard.
- R5: In post-ring mode (preRingMode=0), the end of the first burst of a session opens the caller-ID window (cidEnable=1). The start of the next burst closes it (cidEnable=0). cidEnable is 0 while a burst is in progress.
- R6: In post-ring mode, an open window with no new burst closes after CID_WINDOW_MS ticks, and the block returns to idle.
- R7: Only the first burst of a session opens a window; later bursts end in idle. A session ends after SILENCE_MS ticks in idle with no ring start, or when the line goes off-hook.
- R8: In pre-ring mode (preRingMode=1), cidEnable is 1 in idle and during ringing, and a burst end returns the block to idle without opening a window.
- R9: A hangUpReq while off-hook sets hookN to 1 and enters guard for GUARD_MS ticks. Ring events in guard are ignored. An offHookReq in guard is held pending and applied when guard ends.
- R10: stateCode encodes 0=init, 1=idle, 2=ringing, 3=caller-ID window, 4=off-hook, 5=guard.
- R11: While off-hook, ringStart and ringEnd have no effect; only hangUpReq leaves the off-hook state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| msTick | input | 1 | One-cycle pulse per millisecond |
| ringStart | input | 1 | Qualified strobe marking the start of a ring burst |
| ringEnd | input | 1 | Qualified strobe marking the end of a ring burst |
| offHookReq | input | 1 | Host strobe to answer or originate a call |
| hangUpReq | input | 1 | Host strobe to hang up |
| preRingMode | input | 1 | 1: caller ID may come before ringing; 0: it comes after the first burst |
| hookN | output | 1 | Hook control, 1 = on-hook, 0 = off-hook |
| cidEnable | output | 1 | Caller-ID capture enable |
| stateCode | output | 3 | Current sequencer state |

## Verification
A wrong state shows on stateCode at the clock edge after the event that caused it. Because hookN and cidEnable are decoded from that state, they show the same fault in the same cycle. A timer that is wrong or never clears shows as an init, guard, window or silence interval that ends too early or never ends. A pending or session flag stuck at the wrong value shows only later: at the end of init or guard, or at the next burst end, when the window opens or fails to open.

// File: rtl/hookSeqPkg.sv
package hookSeqPkg;

  typedef enum logic [2:0] {
    ST_INIT    = 3'd0,
    ST_IDLE    = 3'd1,
    ST_RINGING = 3'd2,
    ST_CIDWIN  = 3'd3,
    ST_OFFHOOK = 3'd4,
    ST_GUARD   = 3'd5
  } seqState_t;

  typedef struct packed {
    logic clrTimer;
    logic setPending;
    logic clrPending;
    logic setFirst;
    logic clrFirst;
  } seqStrobe_t;

endpackage

// File: rtl/hookSeqTimers.sv
module hookSeqTimers
  import hookSeqPkg::*;
#(
  parameter int INIT_MS       = 50,
  parameter int GUARD_MS      = 100,
  parameter int CID_WINDOW_MS = 4000,
  parameter int SILENCE_MS    = 6000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  seqStrobe_t strobe,
  output logic       initDone,
  output logic       guardDone,
  output logic       windowDone,
  output logic       silenceDone,
  output logic       pendingOff,
  output logic       firstSeen
);

  localparam int MAX_A = (INIT_MS > GUARD_MS) ? INIT_MS : GUARD_MS;
  localparam int MAX_B = (CID_WINDOW_MS > SILENCE_MS) ? CID_WINDOW_MS : SILENCE_MS;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(MAX_C);
  localparam logic [CW-1:0] INIT_C   = CW'(INIT_MS);
  localparam logic [CW-1:0] GUARD_C  = CW'(GUARD_MS);
  localparam logic [CW-1:0] WINDOW_C = CW'(CID_WINDOW_MS);
  localparam logic [CW-1:0] SILENT_C = CW'(SILENCE_MS);

  logic [CW-1:0] tickCount;

  // Millisecond counter, restarted on every state change, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  tickCount <= '0;
    else if (strobe.clrTimer)                   tickCount <= '0;
    else if (msTick && tickCount != CNT_MAX)    tickCount <= tickCount + 1'b1;
  end

  assign initDone    = tickCount >= INIT_C;
  assign guardDone   = tickCount >= GUARD_C;
  assign windowDone  = tickCount >= WINDOW_C;
  assign silenceDone = tickCount >= SILENT_C;

  // Request held while the line must stay on-hook.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pendingOff <= 1'b0;
    else if (strobe.clrPending) pendingOff <= 1'b0;
    else if (strobe.setPending) pendingOff <= 1'b1;
  end

  // Marks that the current ring session already had its first burst.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                firstSeen <= 1'b0;
    else if (strobe.clrFirst) firstSeen <= 1'b0;
    else if (strobe.setFirst) firstSeen <= 1'b1;
  end

  p_timer_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (msTick && !strobe.clrTimer && tickCount != CNT_MAX)
      |=> (tickCount == $past(tickCount) + 1'b1));

  p_timer_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrTimer |=> (tickCount == '0));

  p_pending_cancel_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrPending |=> !pendingOff);

endmodule

// File: rtl/hookSeqCtrl.sv
module hookSeqCtrl
  import hookSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ringStart,
  input  logic       ringEnd,
  input  logic       offHookReq,
  input  logic       hangUpReq,
  input  logic       preRingMode,
  input  logic       initDone,
  input  logic       guardDone,
  input  logic       windowDone,
  input  logic       silenceDone,
  input  logic       pendingOff,
  input  logic       firstSeen,
  output seqStrobe_t strobe,
  output logic       hookN,
  output logic       cidEnable,
  output logic [2:0] stateCode
);

  seqState_t state, nextState;
  logic      answerNow;
  logic      holdDone;

  assign answerNow = offHookReq && !hangUpReq;
  assign holdDone  = (state == ST_INIT) ? initDone : guardDone;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_INIT, ST_GUARD: begin
        strobe.setPending = answerNow;
        if (holdDone) nextState = (pendingOff || answerNow) ? ST_OFFHOOK : ST_IDLE;
      end
      ST_IDLE: begin
        if (answerNow)                       nextState = ST_OFFHOOK;
        else if (ringStart && !hangUpReq)    nextState = ST_RINGING;
        else if (firstSeen && silenceDone)   strobe.clrFirst = 1'b1;
      end
      ST_RINGING: begin
        if (answerNow) nextState = ST_OFFHOOK;
        else if (ringEnd) begin
          strobe.setFirst = 1'b1;
          nextState = (!preRingMode && !firstSeen) ? ST_CIDWIN : ST_IDLE;
        end
      end
      ST_CIDWIN: begin
        if (answerNow)       nextState = ST_OFFHOOK;
        else if (ringStart)  nextState = ST_RINGING;
        else if (windowDone) nextState = ST_IDLE;
      end
      ST_OFFHOOK: begin
        if (hangUpReq) nextState = ST_GUARD;
      end
      default: nextState = ST_INIT;
    endcase
    strobe.clrTimer   = (nextState != state);
    strobe.clrPending = hangUpReq || (nextState == ST_OFFHOOK);
    if (nextState == ST_OFFHOOK && state != ST_OFFHOOK) strobe.clrFirst = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_INIT;
    else       state <= nextState;
  end

  assign hookN     = (state != ST_OFFHOOK);
  assign cidEnable = (state == ST_CIDWIN) ||
                     (preRingMode && (state == ST_IDLE || state == ST_RINGING));
  assign stateCode = state;

  p_init_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INIT && !initDone) |=> hookN);

  p_cid_offhook_r4: assert property (@(posedge clk) disable iff (!rstN)
    !hookN |-> !cidEnable);

  p_window_close_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CIDWIN && ringStart && !offHookReq) |=> (state == ST_RINGING));

  p_guard_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GUARD && !guardDone) |=> hookN);

  p_state_legal_r10: assert property (@(posedge clk) disable iff (!rstN)
    stateCode <= 3'd5);

  p_ring_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFFHOOK && !hangUpReq) |=> (state == ST_OFFHOOK));

endmodule

// File: rtl/hookCidSequencer.sv
module hookCidSequencer
  import hookSeqPkg::*;
#(
  parameter int INIT_MS       = 50,
  parameter int GUARD_MS      = 100,
  parameter int CID_WINDOW_MS = 4000,
  parameter int SILENCE_MS    = 6000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       ringStart,
  input  logic       ringEnd,
  input  logic       offHookReq,
  input  logic       hangUpReq,
  input  logic       preRingMode,
  output logic       hookN,
  output logic       cidEnable,
  output logic [2:0] stateCode
);

  seqStrobe_t strobe;
  logic initDone, guardDone, windowDone, silenceDone, pendingOff, firstSeen;

  hookSeqTimers #(
    .INIT_MS(INIT_MS), .GUARD_MS(GUARD_MS),
    .CID_WINDOW_MS(CID_WINDOW_MS), .SILENCE_MS(SILENCE_MS)
  ) uTimers (
    .clk(clk), .rstN(rstN), .msTick(msTick), .strobe(strobe),
    .initDone(initDone), .guardDone(guardDone), .windowDone(windowDone),
    .silenceDone(silenceDone), .pendingOff(pendingOff), .firstSeen(firstSeen)
  );

  hookSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .ringStart(ringStart), .ringEnd(ringEnd),
    .offHookReq(offHookReq), .hangUpReq(hangUpReq), .preRingMode(preRingMode),
    .initDone(initDone), .guardDone(guardDone), .windowDone(windowDone),
    .silenceDone(silenceDone), .pendingOff(pendingOff), .firstSeen(firstSeen),
    .strobe(strobe), .hookN(hookN), .cidEnable(cidEnable), .stateCode(stateCode)
  );

endmodule

// File: tb/hookCidSequencer_test.sv
module hookCidSequencer_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic ringStart = 1'b0, ringEnd = 1'b0, offHookReq = 1'b0, hangUpReq = 1'b0;
  logic preRingMode = 1'b0;
  logic hookN, cidEnable;
  logic [2:0] stateCode;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  hookCidSequencer uut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .ringStart(ringStart),
    .ringEnd(ringEnd), .offHookReq(offHookReq), .hangUpReq(hangUpReq),
    .preRingMode(preRingMode), .hookN(hookN), .cidEnable(cidEnable),
    .stateCode(stateCode)
  );

  always #10 clk = ~clk;

  // One tick every 4 clocks.
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      msTick = 1'b1;
      @(negedge clk);
      msTick = 1'b0;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOut(string req, int st, int hk, int cid);
    check({req, " state"}, stateCode, st);
    check({req, " hookN"}, hookN, hk);
    check({req, " cidEnable"}, cidEnable, cid);
  endtask

  task automatic waitTicks(int n);
    repeat (n * 4) @(negedge clk);
  endtask

  // Pulse for one clock; sampling after return sees the post-edge value.
  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: ringStart = 1'b1;
      1: ringEnd = 1'b1;
      2: offHookReq = 1'b1;
      3: hangUpReq = 1'b1;
      default: begin offHookReq = 1'b1; hangUpReq = 1'b1; end
    endcase
    @(negedge clk);
    ringStart = 1'b0; ringEnd = 1'b0; offHookReq = 1'b0; hangUpReq = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    checkOut("R1 reset", 0, 1, 0);
    rstN = 1'b1;
  endtask

  task automatic testInitPending();
    doReset();
    waitTicks(5);
    pulse(2);
    checkOut("R2 request held in init", 0, 1, 0);
    pulse(0);
    check("R1 ring ignored in init", stateCode, 0);
    waitTicks(38);
    checkOut("R1 still on-hook before INIT_MS", 0, 1, 0);
    waitTicks(12);
    checkOut("R2 pending applied R10", 4, 0, 0);
    pulse(0);
    pulse(1);
    checkOut("R11 ring ignored off-hook", 4, 0, 0);
    pulse(3);
    checkOut("R9 hang-up enters guard", 5, 1, 0);
    pulse(0);
    checkOut("R9 ring ignored in guard", 5, 1, 0);
    waitTicks(105);
    checkOut("R9 guard ends idle", 1, 1, 0);
  endtask

  task automatic testInitCancel();
    doReset();
    waitTicks(5);
    pulse(2);
    waitTicks(5);
    pulse(3);
    waitTicks(50);
    checkOut("R2 cancelled request", 1, 1, 0);
  endtask

  task automatic testPostRing();
    preRingMode = 1'b0;
    @(negedge clk);
    checkOut("R5 idle post mode", 1, 1, 0);
    pulse(0);
    checkOut("R5 first burst", 2, 1, 0);
    pulse(1);
    checkOut("R5 window open", 3, 1, 1);
    waitTicks(100);
    pulse(0);
    checkOut("R5 window closed by burst", 2, 1, 0);
    pulse(1);
    checkOut("R7 second burst no window", 1, 1, 0);
    pulse(0);
    pulse(1);
    checkOut("R7 third burst no window", 1, 1, 0);
    waitTicks(6010);
    pulse(0);
    pulse(1);
    checkOut("R7 new session window", 3, 1, 1);
    waitTicks(3990);
    check("R6 window before timeout", cidEnable, 1);
    waitTicks(15);
    checkOut("R6 window timeout", 1, 1, 0);
    pulse(4);
    checkOut("R3 hang-up wins", 1, 1, 0);
    pulse(2);
    checkOut("R3 answer from idle R4", 4, 0, 0);
    pulse(3);
    waitTicks(50);
    pulse(2);
    check("R9 request held in guard", stateCode, 5);
    waitTicks(55);
    checkOut("R9 pending applied after guard", 4, 0, 0);
    pulse(3);
    waitTicks(105);
    pulse(0);
    pulse(1);
    checkOut("R7 hang-up ended session", 3, 1, 1);
    pulse(2);
    checkOut("R3 answer from window R4", 4, 0, 0);
    pulse(3);
    waitTicks(105);
  endtask

  task automatic testPreRing();
    preRingMode = 1'b1;
    @(negedge clk);
    checkOut("R8 idle pre mode", 1, 1, 1);
    pulse(0);
    checkOut("R8 ringing pre mode", 2, 1, 1);
    pulse(1);
    checkOut("R8 burst end idle", 1, 1, 1);
    pulse(0);
    pulse(2);
    checkOut("R3 answer while ringing R4", 4, 0, 0);
    pulse(3);
    checkOut("R4 guard no capture", 5, 1, 0);
    waitTicks(105);
    check("R8 capture after guard", cidEnable, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testInitPending();
    testInitCancel();
    testPostRing();
    testPreRing();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule